// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block holds a programmable calendar alarm and compares it with the running date and time. The time arrives as seven BCD byte lanes: seconds, minutes, hours, weekday, day of month, month and year. A one-cycle seconds tick marks each new second. Software writes alarm fields into a staging set through simple write strobes. A separate commit strobe copies the whole staging set into the active compare set in one step, so a partly written alarm is never compared.

Each alarm field carries its own compare-enable flag, and the comparison uses only the fields whose flag is set. When every enabled field equals the current time on a seconds tick, a sticky status flag is raised. The interrupt line is that flag gated by an interrupt-enable bit. Software clears the flag by writing a one to it.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset the status flag, the interrupt enable and the interrupt line are all 0, and no alarm field is enabled.
- R2: A staging write with `fld_we` high stores `wr_data` bits masked to the width of the field chosen by `fld_idx`, and bit 15 as that field's compare enable. The index order is 0 seconds (7 bits), 1 minutes (7), 2 hours (6), 3 weekday (3), 4 day (6), 5 month (5), 6 year (8). Index 7 is ignored.
- R3: Staged fields do not affect matching until a commit write (`commit_we`) with `wr_data` bit 15 set. A commit write with bit 15 clear has no effect.
- R4: On a seconds tick, a match occurs when every enabled active field equals the matching time lane. A field whose enable is clear is ignored, whatever its value.
- R5: When no active field is enabled, no match occurs.
- R6: Without a seconds tick, no match occurs, even if the time equals the alarm.
- R7: A write with `ien_we` high loads `wr_data` bit 0 into the interrupt enable, which is visible on `alarm_ien` from the next cycle.
- R8: A match sets the status flag whatever the interrupt enable holds. The interrupt line equals the status flag AND the interrupt enable.
- R9: A write with `sts_we` high and `wr_data` bit 0 set clears the status flag. The same write with bit 0 clear leaves the flag unchanged.
- R10: When a match and a clearing write occur in the same cycle, the status flag ends up set.
- R11: The status flag stays set until it is cleared. A further match while it is set changes nothing.
- R12: Each time lane is compared only on the bits within its field width. Higher lane bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_we | input | 1 | Staging field write strobe |
| fld_idx | input | 3 | Staging field index |
| commit_we | input | 1 | Commit register write strobe |
| ien_we | input | 1 | Interrupt enable write strobe |
| sts_we | input | 1 | Status write strobe (write one to clear) |
| wr_data | input | 16 | Write data shared by all strobes |
| sec_tick | input | 1 | One-cycle pulse per second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_wday | input | 8 | Current weekday, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 8 | Current year, BCD |
| alarm_sts | output | 1 | Sticky alarm status flag |
| alarm_ien | output | 1 | Interrupt enable state |
| alarm_irq | output | 1 | Interrupt request level |

## Verification
On every cycle, the assertions check the behaviour of the status and interrupt stage. The flag holds unless it is cleared. It cannot rise without a tick. A compare hit always leaves the flag set, even against a clear. With no field enabled there is never a hit. The interrupt stays low while disabled. Field masking, the rule that a disabled field is ignored, staging without commit, and matches that depend on particular BCD values can only be shown by the bench's scenarios, which compare every cycle against a behavioural model.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

   // number of calendar fields in one alarm set
   localparam int NUM_FLD = 7;
   // width of one time lane on the ports
   localparam int LANE_W  = 8;

   // field width in bits, by field index
   function automatic int fld_width(input int idx);
      case (idx)
         0: return 7;   // seconds
         1: return 7;   // minutes
         2: return 6;   // hours
         3: return 3;   // weekday
         4: return 6;   // day of month
         5: return 5;   // month
         default: return 8;   // year
      endcase
   endfunction

   // mask covering the valid bits of a field
   function automatic logic [LANE_W-1:0] fld_mask(input int idx);
      logic [LANE_W-1:0] m;
      m = '0;
      for (int b = 0; b < LANE_W; b++) begin
         if (b < fld_width(idx)) m[b] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/cal_alarm_stage.sv
module cal_alarm_stage
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int IDX_W    = 3,
   parameter int TRIG_BIT = 15,
   localparam int VAL_W   = DATA_W - 1,
   localparam int EN_BIT  = DATA_W - 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fld_we,
   input  logic [IDX_W-1:0]              fld_idx,
   input  logic                          commit_we,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [NUM_FLD-1:0][VAL_W-1:0] act_val,
   output logic [NUM_FLD-1:0]            act_en
);

   logic [NUM_FLD-1:0][VAL_W-1:0] stg_val;
   logic [NUM_FLD-1:0]            stg_en;
   logic                          do_commit;

   assign do_commit = commit_we & wr_data[TRIG_BIT];

   generate
      for (genvar gi = 0; gi < NUM_FLD; gi++) begin : g_fld
         localparam logic [VAL_W-1:0] MASK = VAL_W'(fld_mask(gi));
         logic sel;
         assign sel = fld_we && (fld_idx == IDX_W'(gi));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stg_val[gi] <= '0;
               stg_en[gi]  <= 1'b0;
            end else if (sel) begin
               stg_val[gi] <= wr_data[VAL_W-1:0] & MASK;
               stg_en[gi]  <= wr_data[EN_BIT];
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act_val[gi] <= '0;
               act_en[gi]  <= 1'b0;
            end else if (do_commit) begin
               act_val[gi] <= stg_val[gi];
               act_en[gi]  <= stg_en[gi];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
   import cal_alarm_pkg::*;
#(
   parameter int VAL_W = 15
) (
   input  logic                           sec_tick,
   input  logic [NUM_FLD-1:0][VAL_W-1:0]  act_val,
   input  logic [NUM_FLD-1:0]             act_en,
   input  logic [NUM_FLD-1:0][LANE_W-1:0] now_lane,
   output logic                           hit
);

   logic [NUM_FLD-1:0] fld_ok;

   generate
      for (genvar gi = 0; gi < NUM_FLD; gi++) begin : g_cmp
         localparam logic [LANE_W-1:0] MASK = fld_mask(gi);
         logic [VAL_W-1:0] now_v;
         assign now_v      = VAL_W'(now_lane[gi] & MASK);
         assign fld_ok[gi] = !act_en[gi] || (act_val[gi] == now_v);
      end
   endgenerate

   assign hit = sec_tick && (|act_en) && (&fld_ok);

endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq #(
   parameter int DATA_W  = 16,
   parameter int IEN_BIT = 0,
   parameter int STS_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              ien_we,
   input  logic              sts_we,
   input  logic [DATA_W-1:0] wr_data,
   output logic              sts,
   output logic              ien,
   output logic              irq
);

   logic clr;
   assign clr = sts_we & wr_data[STS_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts <= 1'b0;
      end else if (hit) begin
         sts <= 1'b1;
      end else if (clr) begin
         sts <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien <= 1'b0;
      end else if (ien_we) begin
         ien <= wr_data[IEN_BIT];
      end
   end

   assign irq = sts & ien;

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int IDX_W    = 3,
   parameter int TRIG_BIT = 15,
   parameter int IEN_BIT  = 0,
   parameter int STS_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fld_we,
   input  logic [IDX_W-1:0]  fld_idx,
   input  logic              commit_we,
   input  logic              ien_we,
   input  logic              sts_we,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sec_tick,
   input  logic [7:0]        now_sec,
   input  logic [7:0]        now_min,
   input  logic [7:0]        now_hour,
   input  logic [7:0]        now_wday,
   input  logic [7:0]        now_day,
   input  logic [7:0]        now_mon,
   input  logic [7:0]        now_year,
   output logic              alarm_sts,
   output logic              alarm_ien,
   output logic              alarm_irq
);

   localparam int VAL_W = DATA_W - 1;

   generate
      if (DATA_W <= LANE_W + 1) begin : g_bad_dw
         $error("DATA_W too narrow for field values plus enable flag");
      end
      if ((1 << IDX_W) < NUM_FLD) begin : g_bad_idx
         $error("IDX_W cannot address every field");
      end
      if (TRIG_BIT >= DATA_W || IEN_BIT >= DATA_W || STS_BIT >= DATA_W) begin : g_bad_bit
         $error("control bit position outside the data word");
      end
   endgenerate

   logic [NUM_FLD-1:0][LANE_W-1:0] now_lane;
   logic [NUM_FLD-1:0][VAL_W-1:0]  act_val;
   logic [NUM_FLD-1:0]             act_en;
   logic                           cmp_hit;

   assign now_lane = {now_year, now_mon, now_day, now_wday,
                      now_hour, now_min, now_sec};

   cal_alarm_stage #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .TRIG_BIT (TRIG_BIT)
   ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .fld_we    (fld_we),
      .fld_idx   (fld_idx),
      .commit_we (commit_we),
      .wr_data   (wr_data),
      .act_val   (act_val),
      .act_en    (act_en)
   );

   cal_alarm_cmp #(
      .VAL_W (VAL_W)
   ) u_cmp (
      .sec_tick (sec_tick),
      .act_val  (act_val),
      .act_en   (act_en),
      .now_lane (now_lane),
      .hit      (cmp_hit)
   );

   cal_alarm_irq #(
      .DATA_W  (DATA_W),
      .IEN_BIT (IEN_BIT),
      .STS_BIT (STS_BIT)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (cmp_hit),
      .ien_we  (ien_we),
      .sts_we  (sts_we),
      .wr_data (wr_data),
      .sts     (alarm_sts),
      .ien     (alarm_ien),
      .irq     (alarm_irq)
   );

endmodule

// File: rtl/cal_alarm_match_chk.sv
module cal_alarm_match_chk #(
   parameter int DATA_W  = 16,
   parameter int IEN_BIT = 0,
   parameter int STS_BIT = 0,
   parameter int NF      = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_tick,
   input logic              ien_we,
   input logic              sts_we,
   input logic [DATA_W-1:0] wr_data,
   input logic              cmp_hit,
   input logic [NF-1:0]     act_en,
   input logic              alarm_sts,
   input logic              alarm_ien,
   input logic              alarm_irq
);

   // R11
   sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_sts && !(sts_we && wr_data[STS_BIT])) |=> alarm_sts);

   // R6
   no_tick_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_sts && !sec_tick) |=> !alarm_sts);

   // R10
   hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit |=> alarm_sts);

   // R9
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && wr_data[STS_BIT] && !cmp_hit) |=> !alarm_sts);

   // R5
   none_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_en == '0) |-> !cmp_hit);

   // R7
   ien_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ien_we |=> (alarm_ien == $past(wr_data[IEN_BIT])));

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_ien |-> !alarm_irq);

endmodule

bind cal_alarm_match cal_alarm_match_chk #(
   .DATA_W  (DATA_W),
   .IEN_BIT (IEN_BIT),
   .STS_BIT (STS_BIT),
   .NF      (cal_alarm_pkg::NUM_FLD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sec_tick  (sec_tick),
   .ien_we    (ien_we),
   .sts_we    (sts_we),
   .wr_data   (wr_data),
   .cmp_hit   (cmp_hit),
   .act_en    (act_en),
   .alarm_sts (alarm_sts),
   .alarm_ien (alarm_ien),
   .alarm_irq (alarm_irq)
);

// File: tb/test_cal_alarm_match.sv
module test_cal_alarm_match;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fld_we = 1'b0;
   logic [2:0]  fld_idx = '0;
   logic        commit_we = 1'b0;
   logic        ien_we = 1'b0;
   logic        sts_we = 1'b0;
   logic [15:0] wr_data = '0;
   logic        sec_tick = 1'b0;
   logic [7:0]  now_t [7];
   logic        alarm_sts, alarm_ien, alarm_irq;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   cal_alarm_match i_cal_alarm_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .fld_we    (fld_we),
      .fld_idx   (fld_idx),
      .commit_we (commit_we),
      .ien_we    (ien_we),
      .sts_we    (sts_we),
      .wr_data   (wr_data),
      .sec_tick  (sec_tick),
      .now_sec   (now_t[0]),
      .now_min   (now_t[1]),
      .now_hour  (now_t[2]),
      .now_wday  (now_t[3]),
      .now_day   (now_t[4]),
      .now_mon   (now_t[5]),
      .now_year  (now_t[6]),
      .alarm_sts (alarm_sts),
      .alarm_ien (alarm_ien),
      .alarm_irq (alarm_irq)
   );

   // behavioural reference model
   int widths [7] = '{7, 7, 6, 3, 6, 5, 8};
   int m_stg_v [7];
   bit m_stg_e [7];
   int m_act_v [7];
   bit m_act_e [7];
   bit m_sts, m_ien;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_stg_v[k]) begin
            m_stg_v[k] = 0; m_stg_e[k] = 0; m_act_v[k] = 0; m_act_e[k] = 0;
         end
         m_sts = 0; m_ien = 0;
      end else begin
         bit any, all, hit;
         any = 0; all = 1;
         for (int k = 0; k < 7; k++) begin
            if (m_act_e[k]) begin
               any = 1;
               if ((int'(now_t[k]) % (1 << widths[k])) != m_act_v[k]) all = 0;
            end
         end
         hit = sec_tick && any && all;
         if (commit_we && wr_data[15]) begin
            for (int k = 0; k < 7; k++) begin
               m_act_v[k] = m_stg_v[k]; m_act_e[k] = m_stg_e[k];
            end
         end
         if (fld_we && fld_idx < 7) begin
            m_stg_v[fld_idx] = int'(wr_data[7:0]) % (1 << widths[fld_idx]);
            m_stg_e[fld_idx] = wr_data[15];
         end
         if (hit) m_sts = 1;
         else if (sts_we && wr_data[0]) m_sts = 0;
         if (ien_we) m_ien = wr_data[0];
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (alarm_sts !== m_sts || alarm_ien !== m_ien || alarm_irq !== (m_sts & m_ien)) begin
            fails++;
            $display("FAIL R8 model compare: sts/ien/irq=%b%b%b expected %b%b%b",
                     alarm_sts, alarm_ien, alarm_irq, m_sts, m_ien, m_sts & m_ien);
         end
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      fld_we = 0; commit_we = 0; ien_we = 0; sts_we = 0; sec_tick = 0; wr_data = '0;
   endtask

   task automatic stage(input int idx, input logic [7:0] v, input bit en);
      @(negedge clk);
      fld_we = 1; fld_idx = 3'(idx); wr_data = {en, 7'b0, v};
      idle();
   endtask

   task automatic commit(input bit trig);
      @(negedge clk);
      commit_we = 1; wr_data = {trig, 15'b0};
      idle();
   endtask

   task automatic wr_ien(input bit b);
      @(negedge clk);
      ien_we = 1; wr_data = {15'b0, b};
      idle();
   endtask

   task automatic wr_sts(input bit b);
      @(negedge clk);
      sts_we = 1; wr_data = {15'b0, b};
      idle();
   endtask

   task automatic tick(input bit t, input bit clr);
      @(negedge clk);
      sec_tick = t; sts_we = clr; wr_data = {15'b0, clr};
      idle();
   endtask

   task automatic set_time(input logic [7:0] s, mi, h, wd, d, mo, y);
      now_t[0] = s; now_t[1] = mi; now_t[2] = h; now_t[3] = wd;
      now_t[4] = d; now_t[5] = mo; now_t[6] = y;
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sts", alarm_sts, 0);
      chk("R1 ien", alarm_ien, 0);
      chk("R1 irq", alarm_irq, 0);
      // R5 nothing enabled; all-zero time equals all-zero alarm
      tick(1, 0);
      chk("R5 no field enabled", alarm_sts, 0);

      // R2 staged alarm, weekday disabled
      stage(0, 8'h30, 1); stage(1, 8'h15, 1); stage(2, 8'h12, 1);
      stage(3, 8'h05, 0); stage(4, 8'h21, 1); stage(5, 8'h06, 1);
      stage(6, 8'h55, 1);
      stage(7, 8'h99, 1);   // R2 index 7 ignored
      set_time(8'h30, 8'h15, 8'h12, 8'h02, 8'h21, 8'h06, 8'h55);
      tick(1, 0);
      chk("R3 staged only", alarm_sts, 0);
      commit(0);
      tick(1, 0);
      chk("R3 commit bit clear", alarm_sts, 0);
      commit(1);
      tick(0, 0);
      chk("R6 no tick", alarm_sts, 0);
      tick(1, 0);
      chk("R4 match, weekday ignored", alarm_sts, 1);
      chk("R8 irq gated off", alarm_irq, 0);

      wr_ien(1);
      chk("R7 ien set", alarm_ien, 1);
      chk("R8 irq high", alarm_irq, 1);
      tick(1, 0);
      chk("R11 sticky on repeat", alarm_sts, 1);
      wr_sts(0);
      chk("R9 write zero keeps", alarm_sts, 1);
      wr_sts(1);
      chk("R9 w1c clears", alarm_sts, 0);
      chk("R8 irq low", alarm_irq, 0);

      // R4 one enabled field differs
      set_time(8'h31, 8'h15, 8'h12, 8'h02, 8'h21, 8'h06, 8'h55);
      tick(1, 0);
      chk("R4 seconds mismatch", alarm_sts, 0);
      set_time(8'h30, 8'h15, 8'h12, 8'h02, 8'h21, 8'h06, 8'h56);
      tick(1, 0);
      chk("R4 year mismatch", alarm_sts, 0);

      // R10 match and clear together
      set_time(8'h30, 8'h15, 8'h12, 8'h02, 8'h21, 8'h06, 8'h55);
      tick(1, 1);
      chk("R10 set beats clear", alarm_sts, 1);
      wr_sts(1);

      // R12 lane bits above field width ignored
      set_time(8'hB0, 8'h95, 8'hD2, 8'hFA, 8'hE1, 8'hE6, 8'h55);
      tick(1, 0);
      chk("R12 upper lane bits ignored", alarm_sts, 1);
      wr_sts(1);

      // R2 value masked to field width (0xB0 -> 0x30)
      stage(0, 8'hB0, 1); commit(1);
      set_time(8'h30, 8'h15, 8'h12, 8'h02, 8'h21, 8'h06, 8'h55);
      tick(1, 0);
      chk("R2 masked staged value", alarm_sts, 1);
      wr_sts(1);

      // R5 disable every field
      for (int k = 0; k < 7; k++) stage(k, 8'h00, 0);
      commit(1);
      set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      tick(1, 0);
      chk("R5 all disabled", alarm_sts, 0);
      wr_ien(0);
      chk("R7 ien cleared", alarm_ien, 0);

      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule